// File: doc/BRIEF.md
# PWM Time-Base Counter

This block is the timing reference of a pulse-width modulation channel. A 16-bit counter advances once per prescaled tick. It runs in one of four modes: rising, falling, rising-then-falling, or stopped. The counter value, a one-cycle strobe when the counter lands on zero, a one-cycle strobe when it lands on the period, and the present count direction all go to a separate compare-and-action stage that shapes the output waveform.

A single 16-bit control word configures the block. It selects the mode, two prescaler codes and the way a new period is applied. A new period can wait in a shadow copy until the counter next reaches zero, which avoids a glitched cycle. It can also replace the active period at once. The tick rate is the system clock divided by the product of a power of two and a second factor. That second factor is 1 for code 0 and twice the code otherwise.

The direction logic is a small state machine. Its states are HOLD (stopped), RISE and FALL. Selecting the stopped mode moves it to HOLD. Rising mode moves it to RISE and falling mode moves it to FALL. In rising-then-falling mode, HOLD goes to RISE. RISE goes to FALL on the tick taken at or above the period. FALL goes to RISE on the tick taken at zero.

Top module: `pwm_timebase`

## Requirements
- R1: A synchronous active-high reset clears the counter, the prescaler and both period copies, and puts the direction state in HOLD. After reset, rising mode with no period written keeps the counter at 0 and raises the zero strobe on every tick.
- R2: In rising mode (control[1:0]=0) each tick adds 1 to the counter, and a tick taken at or above the active period returns it to 0. The repeat time is F·(P+1) clocks, where F is the prescale factor and P the active period.
- R3: In falling mode (control[1:0]=1) each tick subtracts 1, and a tick taken at 0 reloads the active period. The repeat time is F·(P+1) clocks.
- R4: F = 2^C × H, where C is control[12:10] and H is 1 when control[9:7] is 0, otherwise twice control[9:7]. When the count is running, a tick occurs every F clocks.
- R5: In rising-then-falling mode (control[1:0]=2) the counter climbs to P and then descends to 0. The repeat time is F·2P clocks.
- R6: The zero strobe and the period strobe are registered together with the counter. Each is high for one clock, only after a tick, in the same cycle the counter shows 0 or P.
- R7: Stopped mode (control[1:0]=3) holds the counter, gives no strobes and clears the prescaler. After leaving stopped mode, the first counter change comes exactly F clocks later.
- R8: With control[3]=0 a period write fills only the shadow copy. The active period takes the shadow value on the edge where the counter moves to 0.
- R9: With control[3]=1 a period write sets the active period on the next edge, even in the middle of a count.
- R10: The direction output is 1 while the direction state is FALL and 0 otherwise.
- R11: The full period 0xFFFF is reachable: in rising mode the counter shows 0xFFFF with the period strobe, and 0 with the zero strobe one tick later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl | input | 16 | Mode [1:0], load select [3], high-speed code [9:7], power code [12:10] |
| prd_wr | input | 1 | Period write strobe |
| prd_wdata | input | 16 | Period write value |
| cnt | output | 16 | Counter value |
| zero_evt | output | 1 | Counter-reached-zero strobe |
| prd_evt | output | 1 | Counter-reached-period strobe |
| dir_down | output | 1 | 1 while counting down |

## Verification
Each mode runs with a small period at unit prescale, and the time between strobes is measured: five, six and eight clocks tell the three counting shapes apart. Three divider settings with factors 2, 4 and 12 show whether the high-speed code is doubled and whether the power code shifts. A period change made in the middle of a count separates shadow from immediate loading by the peak value reached before the next zero. The delay to the first change after leaving stopped mode shows that the prescaler restarts from zero.

// File: rtl/pwm_timebase_pkg.sv
package pwm_timebase_pkg;

    typedef enum logic [1:0] {
        MODE_UP     = 2'd0,
        MODE_DOWN   = 2'd1,
        MODE_UPDOWN = 2'd2,
        MODE_FREEZE = 2'd3
    } cnt_mode_e;

    typedef enum logic [1:0] {
        ST_HOLD = 2'd0,
        ST_RISE = 2'd1,
        ST_FALL = 2'd2
    } dir_state_e;

    localparam int MODE_LSB  = 0;
    localparam int LOAD_BIT  = 3;
    localparam int HSDIV_LSB = 7;
    localparam int CKDIV_LSB = 10;

endpackage

// File: rtl/pwm_tb_prescaler.sv
module pwm_tb_prescaler #(
    parameter int HS_W = 3,
    parameter int CK_W = 3,
    parameter int PRE_W = (1 << CK_W) - 1 + HS_W + 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            run,
    input  logic [HS_W-1:0] hs_code,
    input  logic [CK_W-1:0] ck_code,
    output logic            tick
);

    logic [PRE_W-1:0] hs_fac;
    logic [PRE_W-1:0] factor;
    logic [PRE_W-1:0] limit;
    logic [PRE_W-1:0] pre_cnt;

    // Factor: power-of-two stage times the doubled high-speed code
    always_comb begin
        if (hs_code == '0)
            hs_fac = PRE_W'(1);
        else
            hs_fac = PRE_W'({hs_code, 1'b0});
        factor = hs_fac << ck_code;
        limit  = factor - PRE_W'(1);
    end

    assign tick = run && (pre_cnt >= limit);

    always_ff @(posedge clk) begin
        if (rst || !run)
            pre_cnt <= '0;
        else if (tick)
            pre_cnt <= '0;
        else
            pre_cnt <= pre_cnt + PRE_W'(1);
    end

    p_idle_clear_r7: assert property (@(posedge clk) disable iff (rst)
        !run |=> (pre_cnt == '0));

    p_tick_only_running_r4: assert property (@(posedge clk) disable iff (rst)
        tick |=> (pre_cnt == '0));

endmodule

// File: rtl/pwm_tb_period.sv
module pwm_tb_period #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             imm,
    input  logic             wr,
    input  logic [CNT_W-1:0] wdata,
    input  logic             zero_load,
    output logic [CNT_W-1:0] prd_act
);

    logic [CNT_W-1:0] prd_shadow;

    always_ff @(posedge clk) begin
        if (rst) begin
            prd_shadow <= '0;
            prd_act    <= '0;
        end else begin
            if (wr)
                prd_shadow <= wdata;
            if (wr && imm)
                prd_act <= wdata;
            else if (!imm && zero_load)
                prd_act <= prd_shadow;
        end
    end

    p_imm_load_r9: assert property (@(posedge clk) disable iff (rst)
        (wr && imm) |=> (prd_act == $past(wdata)));

    p_shadow_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (!imm && !zero_load) |=> $stable(prd_act));

    p_shadow_swap_r8: assert property (@(posedge clk) disable iff (rst)
        (!imm && zero_load) |=> (prd_act == $past(prd_shadow)));

endmodule

// File: rtl/pwm_tb_counter.sv
module pwm_tb_counter
    import pwm_timebase_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  cnt_mode_e        mode,
    input  logic             tick,
    input  logic [CNT_W-1:0] prd_act,
    output logic [CNT_W-1:0] cnt,
    output logic             zero_evt,
    output logic             prd_evt,
    output logic             dir_down,
    output logic             zero_load
);

    dir_state_e       state, state_n;
    logic [CNT_W-1:0] cnt_n;
    logic             step;

    // State register
    always_ff @(posedge clk) begin
        if (rst)
            state <= ST_HOLD;
        else
            state <= state_n;
    end

    // Next state and next count
    always_comb begin
        state_n = state;
        cnt_n   = cnt;
        unique case (mode)
            MODE_FREEZE: state_n = ST_HOLD;
            MODE_UP: begin
                state_n = ST_RISE;
                if (tick)
                    cnt_n = (cnt >= prd_act) ? '0 : cnt + CNT_W'(1);
            end
            MODE_DOWN: begin
                state_n = ST_FALL;
                if (tick)
                    cnt_n = (cnt == '0) ? prd_act : cnt - CNT_W'(1);
            end
            MODE_UPDOWN: begin
                if (state == ST_FALL) begin
                    if (tick) begin
                        if (cnt == '0) begin
                            state_n = ST_RISE;
                            cnt_n   = (prd_act == '0) ? '0 : CNT_W'(1);
                        end else begin
                            cnt_n = cnt - CNT_W'(1);
                        end
                    end
                end else begin
                    state_n = ST_RISE;
                    if (tick) begin
                        if (cnt >= prd_act) begin
                            state_n = ST_FALL;
                            cnt_n   = (cnt == '0) ? '0 : cnt - CNT_W'(1);
                        end else begin
                            cnt_n = cnt + CNT_W'(1);
                        end
                    end
                end
            end
            default: state_n = ST_HOLD;
        endcase
    end

    assign step      = tick && (mode != MODE_FREEZE);
    assign zero_load = step && (cnt_n == '0);

    // Output registers
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt      <= '0;
            zero_evt <= 1'b0;
            prd_evt  <= 1'b0;
            dir_down <= 1'b0;
        end else begin
            cnt      <= cnt_n;
            zero_evt <= step && (cnt_n == '0);
            prd_evt  <= step && (cnt_n == prd_act);
            dir_down <= (state_n == ST_FALL);
        end
    end

    p_freeze_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_FREEZE) |=> ($stable(cnt) && !zero_evt && !prd_evt));

    p_event_on_tick_r6: assert property (@(posedge clk) disable iff (rst)
        (zero_evt || prd_evt) |-> $past(tick));

    p_up_step_r2: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_UP && tick && cnt < prd_act) |=> (cnt == $past(cnt) + CNT_W'(1)));

    p_down_reload_r3: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_DOWN && tick && cnt == '0) |=> (cnt == $past(prd_act)));

    p_zero_flag_r6: assert property (@(posedge clk) disable iff (rst)
        zero_evt |-> (cnt == '0));

endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
    import pwm_timebase_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int HS_W   = 3,
    parameter int CK_W   = 3,
    parameter int CTRL_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CTRL_W-1:0] ctrl,
    input  logic              prd_wr,
    input  logic [CNT_W-1:0]  prd_wdata,
    output logic [CNT_W-1:0]  cnt,
    output logic              zero_evt,
    output logic              prd_evt,
    output logic              dir_down
);

    localparam int PRE_W = (1 << CK_W) - 1 + HS_W + 1;

    cnt_mode_e        mode;
    logic             imm;
    logic [HS_W-1:0]  hs_code;
    logic [CK_W-1:0]  ck_code;
    logic             tick;
    logic             zero_load;
    logic [CNT_W-1:0] prd_act;
    logic             spare_unused;

    assign mode    = cnt_mode_e'(ctrl[MODE_LSB +: 2]);
    assign imm     = ctrl[LOAD_BIT];
    assign hs_code = ctrl[HSDIV_LSB +: HS_W];
    assign ck_code = ctrl[CKDIV_LSB +: CK_W];
    assign spare_unused = ^{ctrl[2], ctrl[6:4], ctrl[CTRL_W-1:CKDIV_LSB+CK_W]};

    pwm_tb_prescaler #(
        .HS_W (HS_W),
        .CK_W (CK_W),
        .PRE_W(PRE_W)
    ) u_pre (
        .clk    (clk),
        .rst    (rst),
        .run    (mode != MODE_FREEZE),
        .hs_code(hs_code),
        .ck_code(ck_code),
        .tick   (tick)
    );

    pwm_tb_period #(
        .CNT_W(CNT_W)
    ) u_prd (
        .clk      (clk),
        .rst      (rst),
        .imm      (imm),
        .wr       (prd_wr),
        .wdata    (prd_wdata),
        .zero_load(zero_load),
        .prd_act  (prd_act)
    );

    pwm_tb_counter #(
        .CNT_W(CNT_W)
    ) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .mode     (mode),
        .tick     (tick),
        .prd_act  (prd_act),
        .cnt      (cnt),
        .zero_evt (zero_evt),
        .prd_evt  (prd_evt),
        .dir_down (dir_down),
        .zero_load(zero_load)
    );

endmodule

// File: tb/pwm_timebase_test.sv
module pwm_timebase_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] ctrl = 16'h0003;
    logic        prd_wr = 1'b0;
    logic [15:0] prd_wdata = '0;
    logic [15:0] cnt;
    logic        zero_evt, prd_evt, dir_down;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    pwm_timebase uut (
        .clk(clk), .rst(rst), .ctrl(ctrl), .prd_wr(prd_wr), .prd_wdata(prd_wdata),
        .cnt(cnt), .zero_evt(zero_evt), .prd_evt(prd_evt), .dir_down(dir_down)
    );

    function automatic logic [15:0] mk(input logic [1:0] mode, input logic imm,
                                       input logic [2:0] hs, input logic [2:0] ck);
        return {3'b000, ck, hs, 3'b000, imm, 1'b0, mode};
    endfunction

    task automatic chk(input string req, input bit ok, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        ctrl = mk(2'd3, 1'b1, 3'd0, 3'd0);
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic write_prd(input logic [15:0] v);
        prd_wr = 1'b1;
        prd_wdata = v;
        @(negedge clk);
        prd_wr = 1'b0;
    endtask

    // Counts clocks from one strobe to the next; returns at the second strobe
    task automatic interval(input bit which, output int n);
        int g = 0;
        n = 0;
        do begin @(negedge clk); g++; end while (!(which ? prd_evt : zero_evt) && g < 5000);
        do begin @(negedge clk); n++; end while (!(which ? prd_evt : zero_evt) && n < 5000);
    endtask

    task automatic settled(input bit which, output int n);
        int d;
        interval(which, d);
        interval(which, n);
    endtask

    task automatic test_reset();
        do_reset();
        chk("R1 cnt after reset", cnt == 0, cnt, 0);
        chk("R1 strobes after reset", {zero_evt, prd_evt, dir_down} == 3'b000,
            {zero_evt, prd_evt, dir_down}, 0);
        ctrl = mk(2'd0, 1'b1, 3'd0, 3'd0);
        repeat (4) @(negedge clk);
        chk("R1 cleared period keeps cnt 0", cnt == 0, cnt, 0);
        chk("R1 zero strobe every tick", zero_evt == 1'b1, zero_evt, 1);
    endtask

    task automatic test_up();
        int n;
        ctrl = mk(2'd3, 1'b1, 3'd0, 3'd0);
        write_prd(16'd4);
        ctrl = mk(2'd0, 1'b1, 3'd0, 3'd0);
        settled(1'b0, n);
        chk("R2 up zero interval", n == 5, n, 5);
        chk("R6 cnt 0 with zero strobe", cnt == 0, cnt, 0);
        @(negedge clk);
        chk("R6 zero strobe one cycle", zero_evt == 1'b0, zero_evt, 0);
        chk("R10 up dir", dir_down == 1'b0, dir_down, 0);
        settled(1'b1, n);
        chk("R2 up period interval", n == 5, n, 5);
        chk("R6 cnt P with period strobe", cnt == 4, cnt, 4);
    endtask

    task automatic test_prescale();
        int n;
        ctrl = mk(2'd3, 1'b1, 3'd0, 3'd0);
        write_prd(16'd3);
        ctrl = mk(2'd0, 1'b1, 3'd3, 3'd1);
        settled(1'b0, n);
        chk("R4 hs3 ck1 factor 12", n == 48, n, 48);
        ctrl = mk(2'd0, 1'b1, 3'd0, 3'd2);
        settled(1'b0, n);
        chk("R4 hs0 ck2 factor 4", n == 16, n, 16);
        ctrl = mk(2'd0, 1'b1, 3'd1, 3'd0);
        settled(1'b0, n);
        chk("R4 hs1 ck0 factor 2", n == 8, n, 8);
    endtask

    task automatic test_down();
        int n;
        ctrl = mk(2'd3, 1'b1, 3'd0, 3'd0);
        write_prd(16'd5);
        ctrl = mk(2'd1, 1'b1, 3'd0, 3'd0);
        settled(1'b0, n);
        chk("R3 down zero interval", n == 6, n, 6);
        @(negedge clk);
        chk("R3 reload to period", cnt == 5, cnt, 5);
        chk("R10 down dir", dir_down == 1'b1, dir_down, 1);
    endtask

    task automatic test_updown();
        int n;
        ctrl = mk(2'd3, 1'b1, 3'd0, 3'd0);
        write_prd(16'd4);
        ctrl = mk(2'd2, 1'b1, 3'd0, 3'd0);
        settled(1'b0, n);
        chk("R5 updown zero interval", n == 8, n, 8);
        @(negedge clk);
        chk("R5 turn at zero", cnt == 1, cnt, 1);
        chk("R10 rising after zero", dir_down == 1'b0, dir_down, 0);
        settled(1'b1, n);
        chk("R5 updown period interval", n == 8, n, 8);
        @(negedge clk);
        chk("R5 turn at period", cnt == 3, cnt, 3);
        chk("R10 falling after period", dir_down == 1'b1, dir_down, 1);
    endtask

    task automatic test_freeze();
        logic [15:0] held;
        bit quiet = 1'b1;
        bit same  = 1'b1;
        int k = 0;
        ctrl = mk(2'd3, 1'b1, 3'd0, 3'd0);
        write_prd(16'd3);
        ctrl = mk(2'd0, 1'b1, 3'd3, 3'd1);
        repeat (30) @(negedge clk);
        ctrl = mk(2'd3, 1'b1, 3'd3, 3'd1);
        @(negedge clk);
        held = cnt;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (cnt != held) same = 1'b0;
            if (zero_evt || prd_evt) quiet = 1'b0;
        end
        chk("R7 freeze holds cnt", same, cnt, held);
        chk("R7 freeze no strobes", quiet, 0, 1);
        ctrl = mk(2'd0, 1'b1, 3'd3, 3'd1);
        do begin @(negedge clk); k++; end while (cnt == held && k < 100);
        chk("R7 first change after F clocks", k == 12, k, 12);
    endtask

    task automatic test_shadow();
        int n;
        int mx = 0;
        int g = 0;
        ctrl = mk(2'd3, 1'b1, 3'd0, 3'd0);
        write_prd(16'd4);
        ctrl = mk(2'd0, 1'b1, 3'd0, 3'd0);
        settled(1'b0, n);
        ctrl = mk(2'd0, 1'b0, 3'd0, 3'd0);
        write_prd(16'd9);
        if (cnt > mx) mx = cnt;
        while (!zero_evt && g < 100) begin
            @(negedge clk); g++;
            if (!zero_evt && cnt > mx) mx = cnt;
        end
        chk("R8 old period until zero", mx == 4, mx, 4);
        interval(1'b0, n);
        chk("R8 shadow applied at zero", n == 10, n, 10);
    endtask

    task automatic test_immediate();
        int n;
        int mx = 0;
        int g = 0;
        ctrl = mk(2'd3, 1'b1, 3'd0, 3'd0);
        write_prd(16'd4);
        ctrl = mk(2'd0, 1'b1, 3'd0, 3'd0);
        settled(1'b0, n);
        @(negedge clk);
        write_prd(16'd9);
        while (!zero_evt && g < 100) begin
            if (cnt > mx) mx = cnt;
            @(negedge clk); g++;
        end
        chk("R9 immediate period mid-count", mx == 9, mx, 9);
    endtask

    task automatic test_max();
        int g = 0;
        do_reset();
        write_prd(16'hFFFF);
        ctrl = mk(2'd0, 1'b1, 3'd0, 3'd0);
        do begin @(negedge clk); g++; end while (!prd_evt && g < 70000);
        chk("R11 reaches 0xFFFF", cnt == 16'hFFFF, cnt, 16'hFFFF);
        @(negedge clk);
        chk("R11 wraps to 0", cnt == 0 && zero_evt, cnt, 0);
    endtask

    initial begin
        #(8 * 190000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        test_reset();
        test_up();
        test_prescale();
        test_down();
        test_updown();
        test_freeze();
        test_shadow();
        test_immediate();
        test_max();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule